// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block decides which of the output queues that belong to one transmit port may send its next packet. Each queue is given a priority code between 0 and 9. Codes 0 to 8 become an 8-bit participation mask. An 8-round cycle walks through the mask bits, and a queue may compete in round r only when bit r of its mask is set. A higher code sets more bits, and the set bits are spread across the cycle, so a queue's turns come at intervals instead of in bursts. Code 9 places a queue in a strict-priority group. That group runs from queue 0 upward without gaps, and any request from it beats every weighted queue.

Each queue drives a request line while it holds a packet. Software-side logic sets each queue through a single write port that carries a priority code, an enable bit and a tail bit. The tail bit marks the last queue that belongs to the port. The scheduler holds a registered one-hot grant and the matching queue index until the downstream packet engine accepts it. A new code written while traffic flows changes nothing in the current round. It takes effect at the next round boundary.

Top module: `wrr_qsched`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `gnt_valid` is 0, `gnt` is all zeros, `cur_round` is 0 and `cfg_err` is 0. After reset every queue has code 8 and is enabled, and no queue carries a tail bit.
- R2: Codes 0 to 8 map to round masks 0x00, 0x01, 0x11, 0x49, 0x55, 0x57, 0x77, 0x7F and 0xFF. A weighted queue is granted only while `cur_round` equals r and bit r of its mask is set.
- R3: Take every queue requesting without a break and every grant accepted at once. Over each full 8-round cycle, a weighted queue then receives as many grants as its mask has set bits: 0 for code 0 up to 8 for code 8.
- R4: A write with a code above 9 raises `cfg_err` for exactly the one cycle after the write. The queue then behaves as a weighted queue with mask 0xFF.
- R5: A queue is static when it and every queue below it carry code 9. When any static queue requests, the grant goes to the lowest-numbered static queue that requests, ahead of all weighted queues.
- R6: A code 9 on a queue where some lower queue does not carry code 9 does not make that queue static. It is served as a weighted queue with mask 0xFF.
- R7: Within one round, each eligible weighted queue is granted at most once. The order is round-robin, starting after the last weighted queue granted (queue 0 first after reset). A decision cycle that finds no static request and no eligible weighted queue issues no grant and advances `cur_round` by one, modulo 8.
- R8: When `gnt_valid` is 1, `gnt` is one-hot with bit `gnt_qid` set. The grant stays unchanged until a cycle in which `gnt_accept` is 1, and `gnt_valid` is 0 in the following cycle. `gnt_accept` has no effect while `gnt_valid` is 0.
- R9: A queue whose enable bit is 0 is never granted. Queues numbered above the first queue that has its tail bit set are never granted.
- R10: A configuration write changes scheduling only from the next round advance. Grants that are still due in the current round follow the settings that were active before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NQ | Per-queue request (queue non-empty) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | log2(NQ) | Queue addressed by the write |
| cfg_prio | input | 4 | Priority code 0..9 (above 9 is an error) |
| cfg_en | input | 1 | Queue enable written with the code |
| cfg_tail | input | 1 | Marks the queue as the port's last |
| cfg_err | output | 1 | One-cycle pulse after a write with a code above 9 |
| gnt_accept | input | 1 | Downstream accepts the current grant |
| gnt | output | NQ | One-hot grant |
| gnt_valid | output | 1 | Grant is being offered |
| gnt_qid | output | log2(NQ) | Index of the granted queue |
| cur_round | output | 3 | Current round of the 8-round cycle |

## Verification
The case that needs care is a configuration write that arrives while a round is partly served and a grant is being held. The bench holds `gnt_accept` low after the first grant of a round and rewrites the code of the queue that is due next. It then releases the accept and expects that queue to be granted once more under its old mask before the round advance loads the new code. The bench also makes strict-priority requests and weighted eligibility present in the same decision cycle and requires the lowest static requester to win. It then removes static requesters one at a time and expects the weighted round-robin to take over.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int RND_N       = 8;
  localparam int RND_W       = 3;
  localparam int PRIO_W      = 4;
  localparam int PRIO_STATIC = 9;

  typedef logic [RND_N-1:0] rmask_t;

  // spread the enabled rounds evenly over the 8-round cycle
  function automatic rmask_t prio_to_mask(input logic [PRIO_W-1:0] code);
    case (code)
      4'd0:    return 8'h00;
      4'd1:    return 8'h01;
      4'd2:    return 8'h11;
      4'd3:    return 8'h49;
      4'd4:    return 8'h55;
      4'd5:    return 8'h57;
      4'd6:    return 8'h77;
      4'd7:    return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/wrr_cfg_bank.sv
module wrr_cfg_bank
  import wrr_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [QW-1:0]     wr_q,
  input  logic [PRIO_W-1:0] wr_code,
  input  logic              wr_on,
  input  logic              wr_last,
  input  logic              commit,
  output logic              bad_code,
  output rmask_t [NQ-1:0]   act_mask,
  output logic [NQ-1:0]     act_static,
  output logic [NQ-1:0]     act_live
);
  // shadow settings, written at any time
  logic [NQ-1:0][PRIO_W-1:0] sh_code;
  logic [NQ-1:0]             sh_on;
  logic [NQ-1:0]             sh_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) begin
        sh_code[i] <= PRIO_W'(8);
        sh_on[i]   <= 1'b1;
        sh_last[i] <= 1'b0;
      end
      bad_code <= 1'b0;
    end else begin
      bad_code <= wr_stb && (wr_code > PRIO_W'(PRIO_STATIC));
      if (wr_stb) begin
        sh_code[wr_q] <= wr_code;
        sh_on[wr_q]   <= wr_on;
        sh_last[wr_q] <= wr_last;
      end
    end
  end

  // derived view of the shadow settings
  rmask_t [NQ-1:0] nx_mask;
  logic [NQ-1:0]   nx_static;
  logic [NQ-1:0]   nx_live;
  logic [NQ-1:0]   in_port;
  logic [NQ-1:0]   stat_run;

  always_comb begin
    in_port  = '0;
    stat_run = '0;
    for (int i = 0; i < NQ; i++) begin
      if (i == 0) begin
        in_port[i]  = 1'b1;
        stat_run[i] = (sh_code[i] == PRIO_W'(PRIO_STATIC));
      end else begin
        in_port[i]  = in_port[i-1] & ~sh_last[i-1];
        stat_run[i] = stat_run[i-1] & (sh_code[i] == PRIO_W'(PRIO_STATIC));
      end
    end
  end

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_derive
      assign nx_mask[g]   = prio_to_mask(sh_code[g]);
      assign nx_static[g] = stat_run[g] & in_port[g];
      assign nx_live[g]   = sh_on[g] & in_port[g];
    end
  endgenerate

  // active settings, loaded only at a round boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) act_mask[i] <= 8'hFF;
      act_static <= '0;
      act_live   <= '1;
    end else if (commit) begin
      act_mask   <= nx_mask;
      act_static <= nx_static;
      act_live   <= nx_live;
    end
  end
endmodule

// File: rtl/wrr_low_pick.sv
module wrr_low_pick #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0] vec,
  output logic          found,
  output logic [QW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (vec[i]) idx = QW'(i);
    end
  end
endmodule

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0] vec,
  input  logic [QW-1:0] last,
  output logic          found,
  output logic [QW-1:0] idx
);
  logic [QW-1:0] probe;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    probe = '0;
    for (int k = 1; k <= NQ; k++) begin
      probe = QW'((int'(last) + k) % NQ);
      if (!found && vec[probe]) begin
        found = 1'b1;
        idx   = probe;
      end
    end
  end
endmodule

// File: rtl/wrr_qsched.sv
module wrr_qsched
  import wrr_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NQ-1:0]     req,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_en,
  input  logic              cfg_tail,
  output logic              cfg_err,
  input  logic              gnt_accept,
  output logic [NQ-1:0]     gnt,
  output logic              gnt_valid,
  output logic [QW-1:0]     gnt_qid,
  output logic [RND_W-1:0]  cur_round
);
  rmask_t [NQ-1:0] act_mask;
  logic [NQ-1:0]   act_static;
  logic [NQ-1:0]   act_live;
  logic            commit;

  wrr_cfg_bank #(.NQ(NQ)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (cfg_we),
    .wr_q       (cfg_qid),
    .wr_code    (cfg_prio),
    .wr_on      (cfg_en),
    .wr_last    (cfg_tail),
    .commit     (commit),
    .bad_code   (cfg_err),
    .act_mask   (act_mask),
    .act_static (act_static),
    .act_live   (act_live)
  );

  logic [RND_W-1:0] round_q;
  logic [NQ-1:0]    served_q;
  logic [QW-1:0]    last_q;
  logic [NQ-1:0]    gnt_q;
  logic             gv_q;
  logic [QW-1:0]    qid_q;

  logic [NQ-1:0] round_bit;
  generate
    for (genvar g = 0; g < NQ; g++) begin : g_rbit
      assign round_bit[g] = act_mask[g][round_q];
    end
  endgenerate

  logic [NQ-1:0] st_req, wt_req;
  assign st_req = req & act_static & act_live;
  assign wt_req = req & act_live & ~act_static & round_bit & ~served_q;

  logic          st_found, wt_found;
  logic [QW-1:0] st_idx, wt_idx;

  wrr_low_pick #(.NQ(NQ)) u_static (
    .vec   (st_req),
    .found (st_found),
    .idx   (st_idx)
  );

  wrr_rr_pick #(.NQ(NQ)) u_weighted (
    .vec   (wt_req),
    .last  (last_q),
    .found (wt_found),
    .idx   (wt_idx)
  );

  logic decide;
  assign decide = ~gv_q;
  assign commit = decide & ~st_found & ~wt_found;

  always_ff @(posedge clk) begin
    if (rst) begin
      round_q  <= '0;
      served_q <= '0;
      last_q   <= QW'(NQ - 1);
      gnt_q    <= '0;
      gv_q     <= 1'b0;
      qid_q    <= '0;
    end else if (gv_q) begin
      if (gnt_accept) begin
        gv_q  <= 1'b0;
        gnt_q <= '0;
      end
    end else if (st_found) begin
      gv_q  <= 1'b1;
      qid_q <= st_idx;
      gnt_q <= NQ'(1) << st_idx;
    end else if (wt_found) begin
      gv_q             <= 1'b1;
      qid_q            <= wt_idx;
      gnt_q            <= NQ'(1) << wt_idx;
      last_q           <= wt_idx;
      served_q[wt_idx] <= 1'b1;
    end else begin
      round_q  <= round_q + 1'b1;
      served_q <= '0;
    end
  end

  assign gnt       = gnt_q;
  assign gnt_valid = gv_q;
  assign gnt_qid   = qid_q;
  assign cur_round = round_q;
endmodule

// File: rtl/wrr_qsched_chk.sv
module wrr_qsched_chk #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic [NQ-1:0] req,
  input logic [NQ-1:0] gnt,
  input logic          gnt_valid,
  input logic [QW-1:0] gnt_qid,
  input logic          gnt_accept,
  input logic [2:0]    cur_round,
  input logic [NQ-1:0] st_set
);
  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ($onehot(gnt) && gnt[gnt_qid]));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !gnt_valid |-> (gnt == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !gnt_accept) |=> (gnt_valid && $stable(gnt_qid)));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && gnt_accept) |=> !gnt_valid);

  p_requester_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_valid) |-> ((($past(req) >> gnt_qid) & NQ'(1)) != '0));

  p_static_first_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(gnt_valid) && ($past(req & st_set) != '0)) |->
      (gnt == ($past(req & st_set) & (~$past(req & st_set) + NQ'(1)))));

  p_round_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |=> $stable(cur_round));

  p_round_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_round) |-> (cur_round == $past(cur_round) + 3'd1));
endmodule

bind wrr_qsched wrr_qsched_chk #(.NQ(NQ)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .gnt        (gnt),
  .gnt_valid  (gnt_valid),
  .gnt_qid    (gnt_qid),
  .gnt_accept (gnt_accept),
  .cur_round  (cur_round),
  .st_set     (act_static)
);

// File: tb/sim_wrr_qsched.sv
module sim_wrr_qsched;
  localparam int NQ   = 8;
  localparam int NCYC = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req;
  logic       cfg_we, cfg_en, cfg_tail, gnt_accept;
  logic [2:0] cfg_qid;
  logic [3:0] cfg_prio;
  logic       cfg_err, gnt_valid;
  logic [7:0] gnt;
  logic [2:0] gnt_qid, cur_round;

  always #5 clk = ~clk;

  wrr_qsched #(.NQ(NQ)) u0 (
    .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
    .cfg_prio(cfg_prio), .cfg_en(cfg_en), .cfg_tail(cfg_tail),
    .cfg_err(cfg_err), .gnt_accept(gnt_accept), .gnt(gnt),
    .gnt_valid(gnt_valid), .gnt_qid(gnt_qid), .cur_round(cur_round)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int exp_cnt [8];
  logic [7:0] exp_msk [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input int code);
    case (code)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h11; 3: return 8'h49;
      4: return 8'h55; 5: return 8'h57; 6: return 8'h77; 7: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; cfg_we = 0; cfg_qid = '0; cfg_prio = '0;
    cfg_en = 0; cfg_tail = 0; gnt_accept = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_wr(input int q, input int code, input bit en, input bit tail);
    cfg_we = 1'b1; cfg_qid = 3'(q); cfg_prio = 4'(code); cfg_en = en; cfg_tail = tail;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_gnt(input string tag);
    for (int t = 0; t < 40 && !gnt_valid; t++) @(negedge clk);
    chk(gnt_valid, tag, gnt_valid, 1);
  endtask

  // counts accepted grants over NCYC full 8-round cycles
  task automatic measure(input logic [7:0] rq, input string tag);
    int cnt [8];
    int wraps;
    logic [2:0] prev;
    for (int q = 0; q < 8; q++) cnt[q] = 0;
    wraps = 0;
    req = rq; gnt_accept = 1'b1;
    prev = cur_round;
    while (wraps < NCYC + 1) begin
      @(negedge clk);
      if (prev == 3'd7 && cur_round == 3'd0) wraps++;
      prev = cur_round;
      if (wraps >= 1 && wraps <= NCYC && gnt_valid) begin
        cnt[gnt_qid]++;
        // R2: granted only in rounds its mask enables
        chk(exp_msk[gnt_qid][cur_round], {tag, " R2 round bit"},
            int'(cur_round), int'(gnt_qid));
      end
    end
    for (int q = 0; q < 8; q++)
      chk(cnt[q] == NCYC * exp_cnt[q], {tag, $sformatf(" q%0d count", q)},
          cnt[q], NCYC * exp_cnt[q]);
    req = '0; gnt_accept = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!gnt_valid && gnt == 0, "R1 no grant", int'(gnt), 0);
    chk(cur_round == 0, "R1 round", int'(cur_round), 0);
    chk(!cfg_err, "R1 err", int'(cfg_err), 0);
    gnt_accept = 1'b1;
    repeat (4) @(negedge clk);
    chk(!gnt_valid, "R8 accept without grant", int'(gnt_valid), 0);
    gnt_accept = 1'b0;
    // R1 defaults: all code 8 -> each queue 8 grants per cycle
    for (int q = 0; q < 8; q++) begin exp_cnt[q] = 8; exp_msk[q] = 8'hFF; end
    measure(8'hFF, "R1 default");
  endtask

  task automatic t_ratio();
    do_reset();
    for (int q = 0; q < 8; q++) cfg_wr(q, q + 1, 1, 0);
    repeat (3) @(negedge clk);
    for (int q = 0; q < 8; q++) begin
      exp_msk[q] = mask_of(q + 1);
      exp_cnt[q] = $countones(exp_msk[q]);
    end
    measure(8'hFF, "R3 ratio");
  endtask

  task automatic t_zero_err();
    do_reset();
    for (int q = 0; q < 8; q++) if (q != 2) cfg_wr(q, (q == 5) ? 1 : 0, 1, 0);
    cfg_we = 1'b1; cfg_qid = 3'd2; cfg_prio = 4'd13; cfg_en = 1; cfg_tail = 0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err, "R4 err pulse", int'(cfg_err), 1);
    @(negedge clk);
    chk(!cfg_err, "R4 err single cycle", int'(cfg_err), 0);
    repeat (2) @(negedge clk);
    for (int q = 0; q < 8; q++) begin exp_cnt[q] = 0; exp_msk[q] = 8'h00; end
    exp_cnt[5] = 1; exp_msk[5] = 8'h01;
    exp_cnt[2] = 8; exp_msk[2] = 8'hFF;
    measure(8'hFF, "R2 R4 zero/invalid");
  endtask

  task automatic t_static();
    do_reset();
    cfg_wr(0, 9, 1, 0);
    cfg_wr(1, 9, 1, 0);
    repeat (3) @(negedge clk);
    req = 8'hFF;
    wait_gnt("R5 grant");
    chk(gnt_qid == 0, "R5 lowest static", int'(gnt_qid), 0);
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk(gnt_valid && gnt_qid == 0 && gnt == 8'h01, "R8 hold", int'(gnt), 1);
    end
    gnt_accept = 1'b1; req = 8'hFE;
    @(negedge clk);
    gnt_accept = 1'b0;
    chk(!gnt_valid, "R8 drop after accept", int'(gnt_valid), 0);
    @(negedge clk);
    chk(gnt_valid && gnt_qid == 1, "R5 next static", int'(gnt_qid), 1);
    gnt_accept = 1'b1; req = 8'hFC;
    @(negedge clk);
    gnt_accept = 1'b0;
    @(negedge clk);
    chk(gnt_valid && gnt_qid == 2, "R5 weighted after static", int'(gnt_qid), 2);
    gnt_accept = 1'b1; req = 8'hFF;
    @(negedge clk);
    gnt_accept = 1'b0;
    @(negedge clk);
    chk(gnt_valid && gnt_qid == 0, "R5 static returns", int'(gnt_qid), 0);
    gnt_accept = 1'b1; req = '0;
    @(negedge clk);
    gnt_accept = 1'b0;
  endtask

  task automatic t_misplaced();
    do_reset();
    for (int q = 0; q < 8; q++) cfg_wr(q, (q == 2) ? 9 : 1, 1, 0);
    repeat (3) @(negedge clk);
    for (int q = 0; q < 8; q++) begin exp_cnt[q] = 1; exp_msk[q] = 8'h01; end
    exp_cnt[2] = 8; exp_msk[2] = 8'hFF;
    measure(8'hFF, "R6 misplaced static");
  endtask

  task automatic t_order();
    int seq [4];
    seq = '{0, 2, 5, 7};
    do_reset();
    req = 8'b1010_0101; gnt_accept = 1'b1;
    for (int n = 0; n < 8; n++) begin
      wait_gnt("R7 grant");
      chk(gnt_qid == 3'(seq[n % 4]), "R7 rr order", int'(gnt_qid), seq[n % 4]);
      @(negedge clk);
    end
    req = '0; gnt_accept = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_live();
    do_reset();
    cfg_wr(4, 8, 0, 0);
    cfg_wr(5, 8, 1, 1);
    repeat (3) @(negedge clk);
    for (int q = 0; q < 8; q++) begin exp_cnt[q] = 8; exp_msk[q] = 8'hFF; end
    exp_cnt[4] = 0; exp_cnt[6] = 0; exp_cnt[7] = 0;
    exp_msk[4] = 8'h00; exp_msk[6] = 8'h00; exp_msk[7] = 8'h00;
    measure(8'hFF, "R9 enable/tail");
  endtask

  task automatic t_boundary();
    do_reset();
    for (int q = 2; q < 8; q++) cfg_wr(q, 0, 1, 0);
    repeat (3) @(negedge clk);
    req = 8'h03;
    wait_gnt("R10 first grant");
    chk(gnt_qid == 0, "R10 first is q0", int'(gnt_qid), 0);
    cfg_wr(1, 0, 1, 0);
    gnt_accept = 1'b1;
    @(negedge clk);
    gnt_accept = 1'b0;
    @(negedge clk);
    chk(gnt_valid && gnt_qid == 1, "R10 old mask in current round", int'(gnt_qid), 1);
    gnt_accept = 1'b1;
    @(negedge clk);
    for (int q = 0; q < 8; q++) begin exp_cnt[q] = 0; exp_msk[q] = 8'h00; end
    exp_cnt[0] = 8; exp_msk[0] = 8'hFF;
    measure(8'h03, "R10 new mask after boundary");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc == 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    rst = 1'b1; req = '0; cfg_we = 0; cfg_qid = '0; cfg_prio = '0;
    cfg_en = 0; cfg_tail = 0; gnt_accept = 0;
    t_reset();
    t_ratio();
    t_zero_err();
    t_static();
    t_misplaced();
    t_order();
    t_live();
    t_boundary();
    summary();
  end
endmodule